// File: doc/BRIEF.md
# Bus Master Cycle Controller with Reply Timeout

This block is the initiator engine for a synchronous 16-bit bus that has separate address, write-data and read-data paths and a single master. A requester hands it one transfer at a time (a word read, a word write or a byte write) over a valid/ready port. The controller then runs the bus handshake. It presents the address under an address strobe, raises the read or write strobe, waits for the target's reply and closes the cycle in order. It then reports either the read word or a write completion.

A target that never answers cannot hang the bus. The data strobe is allowed at most 64 cycles. If no reply arrives in that time, the controller drops every strobe and emits a one-cycle bus-error pulse. A trap handler can take that pulse as its request. The controller accepts the next transfer only after the reply line has returned low.

Top module: `bus_master_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_as`, `bus_rd`, `bus_wr`, `bus_byte`, `rsp_rvalid`, `rsp_wdone` and `bus_error` are low and `req_ready` is high.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. In the next cycle `bus_as` is high, `bus_addr` holds the request address, no data strobe is active and `req_ready` is low.
- R3: Operation code 0 is a word read. From the second cycle of the transfer, `bus_rd` is high together with `bus_as`, and `bus_wr` and `bus_byte` are low.
- R4: Operation codes 1 and 3 are word writes. `bus_wr` is high with `bus_as`, `bus_byte` is low and `bus_wdata` equals the request data.
- R5: Operation code 2 is a byte write. `bus_wr` and `bus_byte` are high. The byte is taken from `req_wdata[7:0]` and driven on `bus_wdata[7:0]` when `req_addr[0]` is 0, or on `bus_wdata[15:8]` when it is 1. The other half is zero.
- R6: When `bus_ack` is high at an edge during strobe cycle k, with k from 1 to 64, the reply is accepted. In the next cycle the data strobes are low, `bus_as` is still high and exactly one of `rsp_rvalid` (read) or `rsp_wdone` (write) pulses for one cycle. In the cycle after that, `bus_as` is low.
- R7: For a read, `rsp_rdata` equals the `bus_rdata` value present at the accepting edge, during the `rsp_rvalid` cycle.
- R8: After a cycle closes, `req_ready` stays low while `bus_ack` is high. It rises in the cycle after an edge at which `bus_ack` is sampled low.
- R9: If `bus_ack` stays low through strobe cycle 64, then in the next cycle all strobes are low, `bus_error` is high for exactly that one cycle and neither `rsp_rvalid` nor `rsp_wdone` pulses.
- R10: A reply that first arrives in that error cycle (strobe cycle 65) or later produces no response pulse. `req_ready` stays low until the reply falls.
- R11: An asserted `rst_n` aborts a transfer in progress at once and drops every strobe.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_op | input | 2 | 0 word read, 1 word write, 2 byte write, 3 word write |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_rvalid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 16 | Read word |
| rsp_wdone | output | 1 | One-cycle write completion pulse |
| bus_error | output | 1 | One-cycle no-reply error pulse |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data, lane-steered for bytes |
| bus_rdata | input | 16 | Bus read data from target |
| bus_as | output | 1 | Address strobe |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_byte | output | 1 | Byte-write qualifier |
| bus_ack | input | 1 | Target reply |

## Verification
Counting from the accepting edge, the address phase is due one cycle later and strobe cycle 1 two cycles later. A reply sampled at the end of strobe cycle k yields the response pulse in the next cycle and the release of `bus_as` one cycle after that. A missing reply yields `bus_error` in the cycle after strobe cycle 64. The bench drives every input on the falling edge and samples outputs on the falling edge. It steps through each of these cycles explicitly and compares the outputs with values from its own functions. Reply delays of 1 and 64, no reply, a reply in cycle 65, both byte lanes and a reset during a strobe are forced directly. Random transfers fill in the rest.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_WRB = 2'd2,
    OP_WR2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STRB = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4,
    ST_REL  = 3'd5
  } st_e;
endpackage

// File: rtl/bmc_timer.sv
module bmc_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (tick && !at_limit);
    cnt_d  = load ? CW'(1) : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == CW'(LIMIT));

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/bmc_lane.sv
module bmc_lane
  import bmc_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic          addr_lsb,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out
);
  localparam int BW = DW / 2;

  always_comb begin
    data_out = data_in;
    if (op == OP_WRB) begin
      data_out = '0;
      if (addr_lsb) data_out[DW-1:BW] = data_in[BW-1:0];
      else          data_out[BW-1:0]  = data_in[BW-1:0];
    end
  end
endmodule

// File: rtl/bmc_seq.sv
module bmc_seq
  import bmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  op_e  op_q,
  input  logic ack,
  input  logic at_limit,
  output logic accept,
  output logic reply_take,
  output logic tmr_load,
  output logic tmr_tick,
  output logic ready,
  output logic as_o,
  output logic rd_o,
  output logic wr_o,
  output logic byte_o,
  output logic rvalid_o,
  output logic wdone_o,
  output logic err_o
);
  st_e st_q, st_d;
  logic is_rd;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_STRB;
      ST_STRB: begin
        if (ack)           st_d = ST_DONE;
        else if (at_limit) st_d = ST_ERR;
      end
      ST_DONE: st_d = ST_REL;
      ST_ERR:  st_d = ST_REL;
      ST_REL:  if (!ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    is_rd      = (op_q == OP_RD);
    ready      = (st_q == ST_IDLE);
    accept     = ready && req_valid;
    reply_take = (st_q == ST_STRB) && ack;
    tmr_load   = (st_q == ST_ADDR);
    tmr_tick   = (st_q == ST_STRB);
    as_o       = (st_q == ST_ADDR) || (st_q == ST_STRB) || (st_q == ST_DONE);
    rd_o       = (st_q == ST_STRB) && is_rd;
    wr_o       = (st_q == ST_STRB) && !is_rd;
    byte_o     = (st_q == ST_STRB) && (op_q == OP_WRB);
    rvalid_o   = (st_q == ST_DONE) && is_rd;
    wdone_o    = (st_q == ST_DONE) && !is_rd;
    err_o      = (st_q == ST_ERR);
  end
endmodule

// File: rtl/bus_master_ctrl.sv
module bus_master_ctrl
  import bmc_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_rvalid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_wdone,
  output logic          bus_error,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_as,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_byte,
  input  logic          bus_ack
);
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          accept, reply_take, tmr_load, tmr_tick, at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= op_e'(req_op);
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (reply_take) rdata_q <= bus_rdata;
  end

  bmc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_q(op_q),
    .ack(bus_ack), .at_limit(at_limit), .accept(accept),
    .reply_take(reply_take), .tmr_load(tmr_load), .tmr_tick(tmr_tick),
    .ready(req_ready), .as_o(bus_as), .rd_o(bus_rd), .wr_o(bus_wr),
    .byte_o(bus_byte), .rvalid_o(rsp_rvalid), .wdone_o(rsp_wdone),
    .err_o(bus_error)
  );

  bmc_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .tick(tmr_tick),
    .at_limit(at_limit)
  );

  bmc_lane #(.DW(DW)) u_lane (
    .op(op_q), .addr_lsb(addr_q[0]), .data_in(wdata_q), .data_out(bus_wdata)
  );

  assign bus_addr  = addr_q;
  assign rsp_rdata = rdata_q;

  // R2
  addr_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as) |-> !(bus_rd || bus_wr));
  // R5
  byte_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_byte |-> bus_wr);
  // R6
  rsp_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rvalid || rsp_wdone) |-> ($past(bus_ack) && bus_as && !bus_rd && !bus_wr));
  // R6
  as_drop_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rvalid || rsp_wdone) |=> !bus_as);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |=> !bus_error);
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> !(bus_as || rsp_rvalid || rsp_wdone));
  // R8
  ready_after_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> !$past(bus_ack));
endmodule

// File: tb/bus_master_ctrl_tb_top.sv
module bus_master_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_rvalid, rsp_wdone, bus_error;
  logic [15:0] rsp_rdata, bus_addr, bus_wdata, bus_rdata;
  logic        bus_as, bus_rd, bus_wr, bus_byte, bus_ack;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  bus_master_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
    .bus_error(bus_error), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_byte(bus_byte), .bus_ack(bus_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_wdata(input logic [1:0] op,
                                             input logic [15:0] a,
                                             input logic [15:0] d);
    if (op == 2'd2) return a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    return d;
  endfunction

  function automatic logic [3:0] exp_strobes(input logic [1:0] op);
    // {as, rd, wr, byte}
    if (op == 2'd0) return 4'b1100;
    if (op == 2'd2) return 4'b1011;
    return 4'b1010;
  endfunction

  function automatic logic [3:0] strobes();
    return {bus_as, bus_rd, bus_wr, bus_byte};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // delay: 1..64 reply in that strobe cycle; 0 no reply; >=65 late reply
  task automatic run_txn(input logic [1:0] op, input logic [15:0] a,
                         input logic [15:0] d, input logic [15:0] rd,
                         input int delay);
    logic [3:0] es;
    int last;
    es = exp_strobes(op);
    check(req_ready === 1'b1, "R2 ready idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0; req_op = $urandom; req_addr = $urandom; req_wdata = $urandom;
    check(strobes() === 4'b1000, "R2 address phase", {28'd0, strobes()}, 32'h8);
    check(bus_addr === a, "R2 address", {16'd0, bus_addr}, {16'd0, a});
    check(req_ready === 1'b0, "R2 busy", {31'd0, req_ready}, 0);
    step();
    last = (delay >= 1 && delay <= 64) ? delay : 64;
    for (int k = 1; k <= last; k++) begin
      if (op == 2'd0) check(strobes() === es, "R3 read strobes", {28'd0, strobes()}, {28'd0, es});
      else if (op == 2'd2) check(strobes() === es, "R5 byte strobes", {28'd0, strobes()}, {28'd0, es});
      else check(strobes() === es, "R4 write strobes", {28'd0, strobes()}, {28'd0, es});
      if (op != 2'd0 && k == 1) begin
        if (op == 2'd2) check(bus_wdata === exp_wdata(op, a, d), "R5 byte lane",
                              {16'd0, bus_wdata}, {16'd0, exp_wdata(op, a, d)});
        else check(bus_wdata === exp_wdata(op, a, d), "R4 write data",
                   {16'd0, bus_wdata}, {16'd0, exp_wdata(op, a, d)});
      end
      if (k == delay) begin bus_ack = 1'b1; bus_rdata = rd; end
      step();
      bus_rdata = $urandom;
    end
    if (delay >= 1 && delay <= 64) begin
      check(strobes() === 4'b1000, "R6 data strobe drop, R8 window", {28'd0, strobes()}, 32'h8);
      check({rsp_rvalid, rsp_wdone} === ((op == 2'd0) ? 2'b10 : 2'b01), "R6 response pulse",
            {30'd0, rsp_rvalid, rsp_wdone}, (op == 2'd0) ? 2 : 1);
      check(bus_error === 1'b0, "R6 no error", {31'd0, bus_error}, 0);
      if (op == 2'd0) check(rsp_rdata === rd, "R7 read data", {16'd0, rsp_rdata}, {16'd0, rd});
      step();
      check(strobes() === 4'b0000 && !rsp_rvalid && !rsp_wdone, "R6 as release",
            {28'd0, strobes()}, 0);
      check(req_ready === 1'b0, "R8 hold while ack", {31'd0, req_ready}, 0);
      bus_ack = 1'b0;
      step();
      check(req_ready === 1'b1, "R8 ready after ack low", {31'd0, req_ready}, 1);
    end else begin
      check(bus_error === 1'b1, "R9 error pulse", {31'd0, bus_error}, 1);
      check(strobes() === 4'b0000 && !rsp_rvalid && !rsp_wdone, "R9 strobes off",
            {28'd0, strobes()}, 0);
      if (delay >= 65) bus_ack = 1'b1;
      step();
      check(bus_error === 1'b0, "R9 single pulse", {31'd0, bus_error}, 0);
      if (delay >= 65) begin
        for (int j = 0; j < 3; j++) begin
          check(!rsp_rvalid && !rsp_wdone && !req_ready, "R10 late reply ignored",
                {30'd0, rsp_rvalid, rsp_wdone}, 0);
          step();
        end
        bus_ack = 1'b0;
        step();
      end else begin
        step();
      end
      check(req_ready === 1'b1, "R10 ready after error", {31'd0, req_ready}, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    bus_rdata = '0; bus_ack = 1'b0;
    repeat (3) @(negedge clk);
    check(strobes() === 4'b0000 && req_ready && !rsp_rvalid && !rsp_wdone && !bus_error,
          "R1 in reset", {28'd0, strobes()}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(strobes() === 4'b0000 && req_ready === 1'b1 && !bus_error, "R1 after reset",
          {28'd0, strobes()}, 0);

    run_txn(2'd0, 16'h1234, 16'h0, 16'hBEEF, 1);
    run_txn(2'd1, 16'h2000, 16'hA5C3, 16'h0, 1);
    run_txn(2'd2, 16'h3000, 16'h12AB, 16'h0, 3);
    run_txn(2'd2, 16'h3001, 16'h34CD, 16'h0, 2);
    run_txn(2'd3, 16'h4002, 16'h7777, 16'h0, 5);
    run_txn(2'd0, 16'h5550, 16'h0, 16'hC0DE, 64);
    run_txn(2'd1, 16'h6000, 16'h1111, 16'h0, 0);
    run_txn(2'd0, 16'h7000, 16'h0, 16'h2222, 65);

    // R11: reset during strobe phase
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0100; req_wdata = 16'h9999;
    step(); req_valid = 1'b0;
    step(); step();
    rst_n = 1'b0; #1;
    check(strobes() === 4'b0000 && req_ready === 1'b1, "R11 abort on reset",
          {28'd0, strobes()}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(strobes() === 4'b0000 && req_ready === 1'b1, "R1 after abort",
          {28'd0, strobes()}, 0);

    for (int t = 0; t < 40; t++) begin
      logic [1:0] op;
      int dl, pick;
      op = 2'($urandom);
      pick = $urandom_range(0, 9);
      dl = (pick == 0) ? 64 : (pick == 1) ? 0 : $urandom_range(1, 8);
      run_txn(op, 16'($urandom), 16'($urandom), 16'($urandom), dl);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule